// File: doc/BRIEF.md
# Temperature Threshold Interrupt Monitor

This block watches filtered raw temperature readings from a small group of sensors, at most four by default. Each reading comes with a one-cycle valid strobe. The block compares every reading against two programmable limits. The upper limit is the hot limit. The lower limit is the cool-down limit, and it sits below the hot limit to give hysteresis.

Each sensor keeps a normal/hot state. A reading that rises above the hot limit while the sensor is normal records a hot event and moves the sensor to hot. A reading that falls below the cool-down limit while the sensor is hot records a cool-down event and moves the sensor back to normal. Events land in a sticky status word that has two bits per sensor, so software can tell which sensor fired and in which direction. Software clears status bits by writing ones. One interrupt line reports any status bit that is enabled in the interrupt mask.

A mode input chooses how repeated hot crossings are reported. In every-crossing mode, each crossing is recorded. In one-shot mode, a hot crossing is recorded only while that sensor's hot bit is clear.

Top module: `tmon_irq_monitor`

## Requirements
- R1: After synchronous reset, `status` is all zero, `irq` is low and every sensor is in the normal state.
- R2: For an enabled sensor i in the normal state, a valid reading strictly greater than `hot_lim` sets status bit 2*i on that clock edge and moves the sensor to hot. A reading equal to `hot_lim` does nothing.
- R3: For an enabled sensor i in the hot state, a valid reading strictly less than `cool_lim` sets status bit 2*i+1 on that clock edge and returns the sensor to normal. A reading equal to `cool_lim` does nothing.
- R4: A reading that does not cross a limit against the sensor's current state records no event. This covers a hot sensor reading above the hot limit, a normal sensor reading below the cool-down limit, and any reading between the limits.
- R5: With `one_shot` = 1, a hot crossing on sensor i records no event while status bit 2*i is already set. The sensor state still moves to hot. With `one_shot` = 0, every hot crossing records an event.
- R6: A sensor whose `sens_en` bit is 0 never sets a status bit, and its state is forced to normal. After it is enabled again, it starts from the normal state.
- R7: With `clr_we` = 1, exactly the status bits given as ones in `clr_bits` are cleared. If a new event and a clear hit the same bit in the same cycle, the bit stays set.
- R8: `irq` is high exactly when some status bit is set and its `irq_en` bit is set. It updates on the same edge as `status`.
- R9: Sensors are independent. Events on several sensors in the same cycle each set their own bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | N | Per-sensor reading valid strobe |
| smp_raw | input | N*RAW_W | Packed raw readings; sensor i occupies bits [i*RAW_W +: RAW_W] |
| hot_lim | input | RAW_W | Hot limit (raw) |
| cool_lim | input | RAW_W | Cool-down limit (raw), below the hot limit |
| sens_en | input | N | Per-sensor enable map |
| one_shot | input | 1 | 1: report a hot crossing only while its status bit is clear |
| irq_en | input | 2*N | Per-status-bit interrupt enable |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_bits | input | 2*N | Bits to clear when clr_we is high |
| status | output | 2*N | Sticky events: bit 2i hot, bit 2i+1 cool-down, for sensor i |
| irq | output | 1 | Combined interrupt |

## Verification
Readings exactly at each limit and one count past it separate strict from inclusive comparison. Repeated readings on the same side of a limit show whether the hysteresis state stops re-firing. A hot crossing that arrives in the same cycle as a clear of its own bit separates one-shot mode from every-crossing mode, and it also shows the priority of a new event over a clear. Several sensors crossing in the same cycle, a sensor disabled while hot, and a long run of random readings packed around both limits show that each sensor keeps its own state and that the enable map resets that state.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  typedef enum logic {
    TS_NORMAL = 1'b0,
    TS_HOT    = 1'b1
  } tsens_e;

  // Status bit positions inside the per-sensor pair.
  localparam int unsigned HOT_OFS  = 0;
  localparam int unsigned COOL_OFS = 1;
  localparam int unsigned BITS_PER_SENS = 2;
endpackage

// File: rtl/tmon_sensor.sv
module tmon_sensor
  import tmon_pkg::*;
#(
  parameter int RAW_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             vld,
  input  logic [RAW_W-1:0] raw,
  input  logic [RAW_W-1:0] hot_lim,
  input  logic [RAW_W-1:0] cool_lim,
  input  logic             one_shot,
  input  logic             hot_stat,
  output logic             hot_ev,
  output logic             cool_ev
);
  tsens_e st_q;
  logic   rise_x;
  logic   fall_x;

  always_comb begin
    rise_x  = en && vld && (st_q == TS_NORMAL) && (raw > hot_lim);
    fall_x  = en && vld && (st_q == TS_HOT) && (raw < cool_lim);
    hot_ev  = rise_x && !(one_shot && hot_stat);
    cool_ev = fall_x;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q <= TS_NORMAL;
    end else if (rise_x) begin
      st_q <= TS_HOT;
    end else if (fall_x) begin
      st_q <= TS_NORMAL;
    end
  end

  // R6: a disabled sensor falls back to normal
  p_dis_normal_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> (st_q == TS_NORMAL));
  // R2: a recorded hot event leaves the sensor hot
  p_hot_state_r2: assert property (@(posedge clk) disable iff (rst)
    hot_ev |=> (st_q == TS_HOT));
  // R3: a cool-down event leaves the sensor normal
  p_cool_state_r3: assert property (@(posedge clk) disable iff (rst)
    cool_ev |=> (st_q == TS_NORMAL));
  // R5: one-shot mode never re-reports while the bit is still pending
  p_oneshot_r5: assert property (@(posedge clk) disable iff (rst)
    (one_shot && hot_stat) |-> !hot_ev);
endmodule

// File: rtl/tmon_status.sv
module tmon_status #(
  parameter int ST_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] ev,
  input  logic            clr_we,
  input  logic [ST_W-1:0] clr_bits,
  input  logic [ST_W-1:0] irq_en,
  output logic [ST_W-1:0] status,
  output logic            irq
);
  logic [ST_W-1:0] clr_m;
  logic [ST_W-1:0] st_nxt;

  always_comb begin
    clr_m  = clr_we ? clr_bits : '0;
    st_nxt = (status & ~clr_m) | ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= st_nxt;
      irq    <= |(st_nxt & irq_en);
    end
  end

  // R7: a new event always lands, even against a clear
  p_event_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (ev != '0) |=> ((status & $past(ev)) == $past(ev)));
  // R7: cleared bits without a new event go to zero
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((status & $past(clr_bits & ~ev)) == '0));
  // R4: bits only become set through an event
  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((status & ~$past(status)) & ~$past(ev)) == '0));
  // R8: interrupt follows masked status
  p_irq_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == (|(status & $past(irq_en)))));
endmodule

// File: rtl/tmon_irq_monitor.sv
module tmon_irq_monitor
  import tmon_pkg::*;
#(
  parameter int N     = 4,
  parameter int RAW_W = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         smp_vld,
  input  logic [N*RAW_W-1:0]   smp_raw,
  input  logic [RAW_W-1:0]     hot_lim,
  input  logic [RAW_W-1:0]     cool_lim,
  input  logic [N-1:0]         sens_en,
  input  logic                 one_shot,
  input  logic [2*N-1:0]       irq_en,
  input  logic                 clr_we,
  input  logic [2*N-1:0]       clr_bits,
  output logic [2*N-1:0]       status,
  output logic                 irq
);
  localparam int ST_W = BITS_PER_SENS * N;

  logic [ST_W-1:0] ev_vec;

  for (genvar g = 0; g < N; g++) begin : g_sens
    tmon_sensor #(.RAW_W(RAW_W)) u_sens (
      .clk      (clk),
      .rst      (rst),
      .en       (sens_en[g]),
      .vld      (smp_vld[g]),
      .raw      (smp_raw[g*RAW_W +: RAW_W]),
      .hot_lim  (hot_lim),
      .cool_lim (cool_lim),
      .one_shot (one_shot),
      .hot_stat (status[BITS_PER_SENS*g + HOT_OFS]),
      .hot_ev   (ev_vec[BITS_PER_SENS*g + HOT_OFS]),
      .cool_ev  (ev_vec[BITS_PER_SENS*g + COOL_OFS])
    );
  end

  tmon_status #(.ST_W(ST_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev_vec),
    .clr_we   (clr_we),
    .clr_bits (clr_bits),
    .irq_en   (irq_en),
    .status   (status),
    .irq      (irq)
  );
endmodule

// File: tb/tmon_irq_monitor_tb.sv
module tmon_irq_monitor_tb;
  localparam int N = 4;
  localparam int RAW_W = 15;
  localparam int ST_W = 2*N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] smp_vld = '0;
  logic [RAW_W-1:0] raw_a [N];
  logic [N*RAW_W-1:0] smp_raw;
  logic [RAW_W-1:0] hot_lim = 15'd1000;
  logic [RAW_W-1:0] cool_lim = 15'd800;
  logic [N-1:0] sens_en = '1;
  logic one_shot = 1'b0;
  logic [ST_W-1:0] irq_en = '1;
  logic clr_we = 1'b0;
  logic [ST_W-1:0] clr_bits = '0;
  logic [ST_W-1:0] status;
  logic irq;

  int checks = 0;
  int fails = 0;
  logic [ST_W-1:0] exp_st = '0;
  logic exp_irq = 1'b0;
  logic [N-1:0] exp_hot = '0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_pack
    assign smp_raw[g*RAW_W +: RAW_W] = raw_a[g];
  end

  tmon_irq_monitor #(.N(N), .RAW_W(RAW_W)) u_dut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_raw(smp_raw),
    .hot_lim(hot_lim), .cool_lim(cool_lim), .sens_en(sens_en),
    .one_shot(one_shot), .irq_en(irq_en), .clr_we(clr_we),
    .clr_bits(clr_bits), .status(status), .irq(irq));

  task automatic model_step();
    logic [ST_W-1:0] ev;
    logic [ST_W-1:0] nx;
    ev = '0;
    for (int i = 0; i < N; i++) begin
      if (!sens_en[i]) exp_hot[i] = 1'b0;
      else if (smp_vld[i]) begin
        if (!exp_hot[i] && raw_a[i] > hot_lim) begin
          exp_hot[i] = 1'b1;
          if (!(one_shot && exp_st[2*i])) ev[2*i] = 1'b1;
        end else if (exp_hot[i] && raw_a[i] < cool_lim) begin
          exp_hot[i] = 1'b0;
          ev[2*i+1] = 1'b1;
        end
      end
    end
    nx = (exp_st & ~(clr_we ? clr_bits : '0)) | ev;
    exp_irq = |(nx & irq_en);
    exp_st = nx;
  endtask

  task automatic check(string tag);
    checks++;
    if (status !== exp_st) begin
      fails++;
      $display("FAIL %s status actual=%h expected=%h at %0t", tag, status, exp_st, $time);
    end
    checks++;
    if (irq !== exp_irq) begin
      fails++;
      $display("FAIL %s/R8 irq actual=%b expected=%b at %0t", tag, irq, exp_irq, $time);
    end
  endtask

  task automatic cyc(string tag);
    model_step();
    @(posedge clk);
    #1;
    check(tag);
    smp_vld = '0;
    clr_we = 1'b0;
    clr_bits = '0;
  endtask

  task automatic samp(int s, int v);
    raw_a[s] = RAW_W'(v);
    smp_vld[s] = 1'b1;
  endtask

  initial begin
    #(4*200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) raw_a[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset");
    rst = 1'b0;
    // R2 boundary: equal to hot limit
    samp(0, 1000); cyc("R2 equal hot limit");
    samp(0, 1001); cyc("R2 hot crossing");
    // R4: stays hot, clear bit0 together with a hot reading
    samp(0, 1500); clr_we = 1; clr_bits = 8'h01; cyc("R4 no refire");
    samp(0, 900); cyc("R4 between limits");
    // R3 boundary and crossing
    samp(0, 800); cyc("R3 equal cool limit");
    samp(0, 799); cyc("R3 cool crossing");
    samp(0, 100); cyc("R4 normal low");
    // R9: two sensors in one cycle
    samp(2, 2000); samp(3, 1200); cyc("R9 simultaneous");
    // R7 exact clear
    clr_we = 1; clr_bits = 8'h10; cyc("R7 exact clear");
    // R5 every crossing with clear of same bit: event wins (R7)
    samp(0, 1200); cyc("R2 hot again");
    samp(0, 700); cyc("R3 cool again");
    samp(0, 1200); clr_we = 1; clr_bits = 8'h01; cyc("R7 event wins");
    // R5 one-shot: suppressed while pending
    one_shot = 1;
    samp(0, 700); cyc("R3 cool");
    samp(0, 1200); clr_we = 1; clr_bits = 8'h01; cyc("R5 one-shot suppressed");
    samp(0, 700); cyc("R5 cool");
    samp(0, 1200); cyc("R5 one-shot fires when clear");
    one_shot = 0;
    // R8 mask
    irq_en = '0; cyc("R8 masked");
    irq_en = 8'h04; cyc("R8 mask unset bit");
    irq_en = 8'h40; cyc("R8 mask set bit");
    irq_en = '1;
    // R6 disabled sensor
    clr_we = 1; clr_bits = '1; cyc("R7 clear all");
    sens_en = 4'b1101; samp(1, 3000); cyc("R6 disabled no event");
    sens_en = 4'b1011; cyc("R6 disable hot sensor2");
    sens_en = 4'b1111; samp(2, 500); cyc("R6 re-enabled normal no cool");
    samp(2, 1500); cyc("R6 re-enabled hot fires");
    // random phase
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < N; i++) begin
        raw_a[i] = RAW_W'(700 + ($urandom % 400));
        smp_vld[i] = ($urandom % 3) != 0;
      end
      sens_en = (($urandom % 10) == 0) ? N'($urandom) : '1;
      if (($urandom % 50) == 0) one_shot = ~one_shot;
      if (($urandom % 20) == 0) irq_en = ST_W'($urandom);
      clr_we = ($urandom % 4) == 0;
      clr_bits = ST_W'($urandom);
      cyc("R4 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
  end
endmodule